// File: doc/BRIEF.md
# Bit-Oriented Message Receiver with HDLC Fallback

This block watches the serial bit stream of a data link and works out whether it carries HDLC frames or repeated bit-oriented message codewords. It starts in HDLC mode. A long run of ones moves it into message mode. An HDLC flag moves it back to HDLC mode at once, so a frame that follows the flag needs no extra leading flags.

In message mode the stream is split into 8-bit slots. A slot holding the all-ones sync pattern is followed by a data slot. A data byte is assembled with its first bit as the least significant bit. It is written to a FIFO write port only when its first and last bits are both zero. Every ten stored bytes close a packet: a status entry follows them, flagged on a separate marker line, and an end-of-packet interrupt is pulsed. A separate interrupt reports when too many bits pass without a sync run. Sampling carries on after that interrupt.

Top module: `bom_receiver`

## Requirements
- R1: After a hardware reset or a one-cycle `soft_rst` strobe, `mode_msg` is 0, the write port and both interrupts are idle, and the count of consecutive ones starts again from zero.
- R2: In HDLC mode, the valid bit that completes eight consecutive ones sets `mode_msg` to 1. Seven consecutive ones followed by a zero leave it at 0.
- R3: In message mode, the valid bit that completes the pattern 0,1,1,1,1,1,1,0 (received in that order) clears `mode_msg`. That bit never produces a write. A partly filled packet is dropped, and the next packet counts from zero.
- R4: The eight bits of a data slot form a byte with the first received bit at bit 0. The byte is written with `wr_status`=0 exactly when bit 0 and bit 7 are both 0. After a stored byte, the next slot is a sync slot.
- R5: A data byte whose bit 0 and bit 7 differ is not written, and the next slot is a sync slot. A data byte whose bit 0 and bit 7 are both 1 is not written, and the next slot is again a data slot.
- R6: A sync slot is always followed by a data slot, even when the sync slot did not hold eight ones.
- R7: In message mode, `irq_sync_loss` pulses for one cycle on the 32nd valid bit after the last completed run of eight ones, unless that bit itself completes such a run. It pulses at most once until the next run.
- R8: The cycle after the tenth stored byte of a packet, the port writes 0x40 with `wr_status`=1, and `irq_msg_end` pulses in that same cycle. Packets repeat for as long as message mode lasts.
- R9: While the run of ones is eight or longer, every further one moves the slot boundary. The data slot starts at the first bit after the run.
- R10: Cycles with `bit_valid`=0 change no state, whatever value `bit_in` has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous return to the reset state |
| bit_in | input | 1 | Serial data bit |
| bit_valid | input | 1 | Qualifies `bit_in` for one cycle |
| mode_msg | output | 1 | 1 in message mode, 0 in HDLC mode |
| wr_en | output | 1 | FIFO write strobe |
| wr_data | output | 8 | FIFO write data |
| wr_status | output | 1 | Marks the write as a packet status entry |
| irq_sync_loss | output | 1 | Pulse: no sync run within 32 bits |
| irq_msg_end | output | 1 | Pulse: packet of ten bytes closed |

## Verification
Take a bit accepted at clock edge k. `mode_msg`, a data write and `irq_sync_loss` all show its effect just after edge k. A status write and `irq_msg_end` follow one edge later, at k+1. The bench drives inputs on falling edges and reads outputs on the next falling edge. Its write monitor pops the expected entry in that same half cycle. Because of this, a status entry that comes a cycle late, or out of order, fails the comparison even when back-to-back bits are being sent.

// File: rtl/bomr_pkg.sv
package bomr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FLAG_PAT  = 8'h7E;
  localparam logic [BYTE_W-1:0] STAT_CODE = 8'h40;

  typedef enum logic {
    SLOT_SYNC = 1'b0,
    SLOT_DATA = 1'b1
  } slot_e;
endpackage

// File: rtl/bomr_detect.sv
module bomr_detect
  import bomr_pkg::*;
#(
  parameter int unsigned RUN_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bit_valid,
  input  logic bit_in,
  output logic run_hit,
  output logic flag_hit
);
  localparam int unsigned RUN_W = $clog2(RUN_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LEN);
  localparam logic [RUN_W-1:0] RUN_PRE = RUN_W'(RUN_LEN - 1);

  logic [RUN_W-1:0]  run_q, run_d;
  logic [BYTE_W-1:0] sr_q, sr_d;
  logic              en;

  assign en = clr | bit_valid;

  always_comb begin
    run_d = run_q;
    sr_d  = sr_q;
    if (clr) begin
      run_d = '0;
      sr_d  = '0;
    end else if (bit_valid) begin
      sr_d = {sr_q[BYTE_W-2:0], bit_in};
      if (!bit_in)               run_d = '0;
      else if (run_q != RUN_MAX) run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      sr_q  <= '0;
    end else if (en) begin
      run_q <= run_d;
      sr_q  <= sr_d;
    end
  end

  assign run_hit  = ~clr & bit_valid & bit_in & (run_q >= RUN_PRE);
  assign flag_hit = ~clr & bit_valid & ({sr_q[BYTE_W-2:0], bit_in} == FLAG_PAT);

  // R2
  hit_needs_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_hit |-> (bit_in && !flag_hit));
endmodule

// File: rtl/bomr_mode.sv
module bomr_mode #(
  parameter int unsigned LOSS_WIN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bit_valid,
  input  logic run_hit,
  input  logic flag_hit,
  output logic msg_o,
  output logic enter_o,
  output logic leave_o,
  output logic irq_loss_o
);
  localparam int unsigned WIN_W = $clog2(LOSS_WIN + 1);
  localparam logic [WIN_W-1:0] WIN_MAX  = WIN_W'(LOSS_WIN);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(LOSS_WIN - 1);

  logic             msg_q, msg_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic             irq_q, irq_d;

  assign enter_o = ~msg_q & run_hit;
  assign leave_o = msg_q & flag_hit;

  always_comb begin
    msg_d = msg_q;
    win_d = win_q;
    irq_d = 1'b0;
    if (clr) begin
      msg_d = 1'b0;
      win_d = '0;
    end else if (enter_o) begin
      msg_d = 1'b1;
      win_d = '0;
    end else if (leave_o) begin
      msg_d = 1'b0;
      win_d = '0;
    end else if (msg_q && bit_valid) begin
      if (run_hit) begin
        win_d = '0;
      end else if (win_q != WIN_MAX) begin
        win_d = win_q + 1'b1;
        irq_d = (win_q == WIN_LAST);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_q <= 1'b0;
      win_q <= '0;
      irq_q <= 1'b0;
    end else begin
      msg_q <= msg_d;
      win_q <= win_d;
      irq_q <= irq_d;
    end
  end

  assign msg_o      = msg_q;
  assign irq_loss_o = irq_q;

  // R7
  loss_in_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> msg_q);
  // R7
  loss_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R1
  clr_to_hdlc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!msg_q && !irq_q));
endmodule

// File: rtl/bomr_sampler.sv
module bomr_sampler
  import bomr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              start,
  input  logic              active,
  input  logic              bit_valid,
  input  logic              bit_in,
  input  logic              run_hit,
  output logic              store_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  slot_e             slot_q, slot_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              store;

  always_comb begin
    slot_d = slot_q;
    cnt_d  = cnt_q;
    byte_d = byte_q;
    store  = 1'b0;
    if (clr || start) begin
      slot_d = SLOT_DATA;
      cnt_d  = '0;
    end else if (active && bit_valid) begin
      if (run_hit) begin
        slot_d = SLOT_DATA;
        cnt_d  = '0;
      end else begin
        byte_d = {bit_in, byte_q[BYTE_W-1:1]};
        if (cnt_q == CNT_LAST) begin
          cnt_d = '0;
          if (slot_q == SLOT_DATA) begin
            if (!byte_d[0] && !byte_d[BYTE_W-1]) begin
              store  = 1'b1;
              slot_d = SLOT_SYNC;
            end else if (byte_d[0] && byte_d[BYTE_W-1]) begin
              slot_d = SLOT_DATA;
            end else begin
              slot_d = SLOT_SYNC;
            end
          end else begin
            slot_d = SLOT_DATA;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= SLOT_DATA;
      cnt_q  <= '0;
      byte_q <= '0;
    end else begin
      slot_q <= slot_d;
      cnt_q  <= cnt_d;
      byte_q <= byte_d;
    end
  end

  assign store_o = store;
  assign byte_o  = byte_d;

  // R4
  store_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_o |-> (active && bit_valid && !run_hit));
  // R9
  realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && run_hit && !clr) |=> (cnt_q == '0 && slot_q == SLOT_DATA));
endmodule

// File: rtl/bomr_packer.sv
module bomr_packer
  import bomr_pkg::*;
#(
  parameter int unsigned PKT_LEN = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              drop,
  input  logic              store_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              wr_stat_o,
  output logic              irq_end_o
);
  localparam int unsigned PKT_W = $clog2(PKT_LEN);
  localparam logic [PKT_W-1:0] PKT_LAST = PKT_W'(PKT_LEN - 1);

  logic [PKT_W-1:0]  cnt_q, cnt_d;
  logic              pend_q, pend_d;
  logic              wen_q, wen_d;
  logic [BYTE_W-1:0] wdat_q, wdat_d;
  logic              wst_q, wst_d;
  logic              irq_q, irq_d;

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    wen_d  = 1'b0;
    wdat_d = wdat_q;
    wst_d  = 1'b0;
    irq_d  = 1'b0;
    if (clr) begin
      cnt_d  = '0;
      pend_d = 1'b0;
    end else begin
      if (pend_q) begin
        wen_d  = 1'b1;
        wdat_d = STAT_CODE;
        wst_d  = 1'b1;
        irq_d  = 1'b1;
        pend_d = 1'b0;
      end
      if (store_i) begin
        wen_d  = 1'b1;
        wdat_d = byte_i;
        wst_d  = 1'b0;
        if (cnt_q == PKT_LAST) begin
          cnt_d  = '0;
          pend_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (drop) begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      wen_q  <= 1'b0;
      wdat_q <= '0;
      wst_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      wen_q  <= wen_d;
      wdat_q <= wdat_d;
      wst_q  <= wst_d;
      irq_q  <= irq_d;
    end
  end

  assign wr_en_o   = wen_q;
  assign wr_data_o = wdat_q;
  assign wr_stat_o = wst_q;
  assign irq_end_o = irq_q;

  // R8
  status_follows_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wst_q |-> $past(wen_q && !wst_q));
  // R8
  no_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_q && store_i));
  // R8
  irq_with_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (wen_q && wst_q));
  // R4
  data_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wen_q && !wst_q) |-> (!wdat_q[0] && !wdat_q[BYTE_W-1]));
endmodule

// File: rtl/bom_receiver.sv
module bom_receiver
  import bomr_pkg::*;
#(
  parameter int unsigned RUN_LEN  = 8,
  parameter int unsigned LOSS_WIN = 32,
  parameter int unsigned PKT_LEN  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              bit_in,
  input  logic              bit_valid,
  output logic              mode_msg,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_status,
  output logic              irq_sync_loss,
  output logic              irq_msg_end
);
  logic              rst_meta, rst_sync;
  logic              run_hit, flag_hit;
  logic              msg, enter, leave;
  logic              store;
  logic [BYTE_W-1:0] cap_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  bomr_detect #(.RUN_LEN(RUN_LEN)) u_detect (
    .clk      (clk),
    .rst_n    (rst_sync),
    .clr      (soft_rst),
    .bit_valid(bit_valid),
    .bit_in   (bit_in),
    .run_hit  (run_hit),
    .flag_hit (flag_hit)
  );

  bomr_mode #(.LOSS_WIN(LOSS_WIN)) u_mode (
    .clk       (clk),
    .rst_n     (rst_sync),
    .clr       (soft_rst),
    .bit_valid (bit_valid),
    .run_hit   (run_hit),
    .flag_hit  (flag_hit),
    .msg_o     (msg),
    .enter_o   (enter),
    .leave_o   (leave),
    .irq_loss_o(irq_sync_loss)
  );

  bomr_sampler u_sampler (
    .clk      (clk),
    .rst_n    (rst_sync),
    .clr      (soft_rst),
    .start    (enter),
    .active   (msg & ~leave),
    .bit_valid(bit_valid),
    .bit_in   (bit_in),
    .run_hit  (run_hit),
    .store_o  (store),
    .byte_o   (cap_byte)
  );

  bomr_packer #(.PKT_LEN(PKT_LEN)) u_packer (
    .clk      (clk),
    .rst_n    (rst_sync),
    .clr      (soft_rst),
    .drop     (leave),
    .store_i  (store),
    .byte_i   (cap_byte),
    .wr_en_o  (wr_en),
    .wr_data_o(wr_data),
    .wr_stat_o(wr_status),
    .irq_end_o(irq_msg_end)
  );

  assign mode_msg = msg;

  // R3
  flag_no_write_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    leave |=> (!msg && !(wr_en && !wr_status)));
endmodule

// File: tb/tb_bom_receiver.sv
module tb_bom_receiver;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       bit_in = 1'b1;
  logic       bit_valid = 1'b0;
  logic       mode_msg, wr_en, wr_status, irq_sync_loss, irq_msg_end;
  logic [7:0] wr_data;

  int checks = 0;
  int errors = 0;
  int gap = 2;
  int loss_cnt = 0;
  int end_cnt = 0;
  int cycles = 0;
  bit running = 1'b0;
  logic [8:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bom_receiver dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bit_in(bit_in),
    .bit_valid(bit_valid), .mode_msg(mode_msg), .wr_en(wr_en),
    .wr_data(wr_data), .wr_status(wr_status),
    .irq_sync_loss(irq_sync_loss), .irq_msg_end(irq_msg_end)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // gap cycles drive bit_in=1 with bit_valid=0 (R10)
  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_valid = 1'b1;
    bit_in    = b;
    @(negedge clk);
    bit_valid = 1'b0;
    bit_in    = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic send_val(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic store_val(input logic [7:0] v, input bit closes);
    exp_q.push_back({1'b0, v});
    if (closes) exp_q.push_back({1'b1, 8'h40});
    send_val(v);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (running) begin
      if (irq_sync_loss) loss_cnt++;
      if (irq_msg_end) end_cnt++;
      if (wr_en) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected write", {wr_status, wr_data}, 0);
        end else begin
          automatic logic [8:0] e = exp_q.pop_front();
          chk({wr_status, wr_data} == e, "R4/R8 write entry", {wr_status, wr_data}, e);
          chk(irq_msg_end == e[8], "R8 irq_msg_end with status", irq_msg_end, e[8]);
        end
      end else if (irq_msg_end) begin
        chk(1'b0, "R8 irq_msg_end without write", 1, 0);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 50000) begin
      chk(1'b0, "watchdog", cycles, 0);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mode_msg == 1'b0 && wr_en == 1'b0 && irq_sync_loss == 1'b0 && irq_msg_end == 1'b0,
        "R1 reset outputs", {mode_msg, wr_en, irq_sync_loss, irq_msg_end}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    running = 1'b1;

    // R2 / R10: seven ones then zero, gaps carry ones with valid low
    send_ones(7);
    send_bit(1'b0);
    chk(mode_msg == 1'b0, "R2 R10 seven ones stay HDLC", mode_msg, 0);
    send_ones(8);
    chk(mode_msg == 1'b1, "R2 eight ones enter message mode", mode_msg, 1);

    // R9: extra ones move the data slot
    send_ones(3);
    store_val(8'h2C, 0);
    send_ones(8);
    store_val(8'h5A, 0);

    // R5 mixed byte rejected, R6 corrupted sync slot still followed by data
    send_ones(8);
    send_val(8'h82);
    send_val(8'h77);
    store_val(8'h24, 0);
    // sync completes exactly on the 32nd bit: no loss interrupt (R7)
    send_ones(8);
    chk(loss_cnt == 0, "R7 no loss when run ends window", loss_cnt, 0);

    // R5 both-ones byte rejected and next slot is data
    send_val(8'h82);
    send_val(8'h00);
    send_val(8'h81);
    store_val(8'h42, 0);
    chk(loss_cnt == 1, "R7 loss after 32 bits", loss_cnt, 1);
    send_val(8'h00);
    chk(loss_cnt == 1, "R7 loss fires once per window", loss_cnt, 1);

    // R8 complete packet with back-to-back bits
    gap = 0;
    for (int i = 0; i < 6; i++) begin
      send_ones(8);
      store_val(8'h10 + 8'(2*i), i == 5);
    end
    repeat (3) @(negedge clk);
    chk(end_cnt == 1, "R8 one end interrupt", end_cnt, 1);

    // R3 partial packet dropped on flag
    gap = 1;
    send_ones(8); store_val(8'h20, 0);
    send_ones(8); store_val(8'h22, 0);
    send_ones(8); store_val(8'h26, 0);
    send_ones(8);
    send_val(8'h7E);
    chk(mode_msg == 1'b0, "R3 flag returns to HDLC", mode_msg, 0);

    // R3 counter restarted: status only after ten new bytes
    send_ones(8);
    chk(mode_msg == 1'b1, "R2 re-enter message mode", mode_msg, 1);
    store_val(8'h30, 0);
    for (int i = 1; i < 10; i++) begin
      send_ones(8);
      store_val(8'h30 + 8'(2*i), i == 9);
    end
    repeat (3) @(negedge clk);
    chk(end_cnt == 2, "R3 R8 second packet end", end_cnt, 2);

    // R1 soft reset clears mode and ones run
    send_ones(5);
    @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk(mode_msg == 1'b0 && wr_en == 1'b0, "R1 soft reset to HDLC", mode_msg, 0);
    send_ones(4);
    chk(mode_msg == 1'b0, "R1 ones run restarted", mode_msg, 0);
    send_ones(4);
    chk(mode_msg == 1'b1, "R2 eight ones after soft reset", mode_msg, 1);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all expected writes seen", exp_q.size(), 0);
    chk(loss_cnt == 1, "R7 total loss interrupts", loss_cnt, 1);
    finish_run();
  end
endmodule